// File: doc/BRIEF.md
# DDR2 Initialization Sequencer

This block brings a set of DDR2 devices from power-up to an operational state by issuing a fixed series of direct memory commands to each populated chip select in turn. A single start pulse launches the run. The block takes a chip count, base values for the mode register and the extended mode register, and a programmable pause length, and samples all of them at the start. It then walks every chip from index 0 upward and emits one 23-bit command word per step over a valid/ready handshake. When the last chip has received its final command, a done flag rises and stays high.

Each chip receives twelve commands and three pauses. The sequence opens with a no-operation and a precharge-all, then a pause. Next come writes to extended registers 2 and 3 and to the extended register itself. The mode register is then written with its DLL-reset bit set, followed by a precharge-all and two auto-refreshes. A second mode-register write clears DLL reset. The sequence ends with an extended-register write that calls up the off-chip-driver calibration default and a further write that leaves it. Pauses sit before the last of these writes and before the one that precedes it. The command words go to a downstream command port that applies them to the DRAM.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, cmdValid and done are both 0.
- R2: The command word carries the chip index in bits 21:20, the memory command in bits 19:18 (0 precharge-all, 1 auto-refresh, 2 mode-register write, 3 no-operation), the bank select in bits 17:16 and the register value in bits 15:0. Bit 22 is always 0. For a mode-register write, bank 0 selects the mode register, bank 1 the extended register, bank 2 extended register 2 and bank 3 extended register 3.
- R3: For each chip the commands are, in order: no-operation, precharge-all, write bank 2, write bank 3, write bank 1, write bank 0 (DLL reset), precharge-all, auto-refresh, auto-refresh, write bank 0, write bank 1 (calibration default), write bank 1 (calibration exit).
- R4: While cmdValid is high and cmdReady is low, cmdValid stays high and cmdWord does not change on the next cycle.
- R5: The write to bank 2, the calibration-default write and the calibration-exit write are each preceded by exactly max(stepDelay,1) cycles with cmdValid low after the previous command's handshake. All other commands follow their predecessor's handshake with no idle cycle.
- R6: Bits 15:0 are 0 for no-operation, precharge-all, auto-refresh and the bank 2 and bank 3 writes. They are modeBase with bit 8 set for the first bank 0 write and modeBase with bit 8 cleared for the second. For the calibration-default write they are extModeBase with bits 9:7 forced to 7. For the first and last bank 1 writes they are extModeBase with bits 9:7 forced to 0.
- R7: Chips are served in ascending order from 0 to one below the chip count. A count above 4 is treated as 4.
- R8: done rises on the cycle after the final handshake. It stays high until the next accepted start and is cleared by a start with a nonzero count.
- R9: A start pulse that arrives while a sequence is running has no effect on the commands issued.
- R10: A start with a chip count of 0 sets done on the next cycle and issues no command.
- R11: chipCount, modeBase, extModeBase and stepDelay are sampled at the accepted start. Later changes to them do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a sequence when the block is idle |
| chipCount | input | 3 | Number of chips to initialize (clamped to 4) |
| modeBase | input | 16 | Base value for mode-register writes |
| extModeBase | input | 16 | Base value for extended-register writes |
| stepDelay | input | DLY_W | Pause length in cycles (0 behaves as 1) |
| cmdReady | input | 1 | Downstream accepts the presented command |
| cmdValid | output | 1 | A command word is presented |
| cmdWord | output | 23 | Packed direct command |
| done | output | 1 | All chips initialized |

## Verification
The bench targets the handshake under random back-pressure. A design that advanced on valid alone, or changed the word during a stall, would drop commands or corrupt one. It checks pause lengths with a stepDelay of 0, where a design without the minimum would skip the pause or wrap a counter through 2^DLY_W cycles. It covers chip counts of 0 and above 4, where the failures would be a hang, stray commands, or chip indices past 3. It also injects a second start and changes the configuration mid-run; a design that re-armed or read the live inputs would restart at chip 0 or emit altered register values.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int CHIP_W    = 2;
  localparam int CNT_W     = CHIP_W + 1;
  localparam int MAX_CHIPS = 1 << CHIP_W;
  localparam int VAL_W     = 16;
  localparam int CMD_W     = 1 + CHIP_W + 2 + 2 + VAL_W;
  localparam int NUM_STEPS = 15;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);
  localparam int DLL_BIT   = 8;
  localparam int OCD_LSB   = 7;
  localparam logic [VAL_W-1:0] DLL_MASK = VAL_W'(1) << DLL_BIT;
  localparam logic [VAL_W-1:0] OCD_MASK = VAL_W'(7) << OCD_LSB;

  typedef enum logic [1:0] {
    MC_PREA = 2'd0,
    MC_AREF = 2'd1,
    MC_MRS  = 2'd2,
    MC_NOP  = 2'd3
  } memCmd_e;

  typedef enum logic [2:0] {
    AD_ZERO,
    AD_MR_DLL,
    AD_MR_RUN,
    AD_EMR_DEF,
    AD_EMR_EXIT
  } addrSel_e;

  typedef struct packed {
    logic       isDelay;
    memCmd_e    cmd;
    logic [1:0] bank;
    addrSel_e   addr;
  } stepInfo_t;

  typedef struct packed {
    logic              loadCfg;
    logic [STEP_W-1:0] stepIdx;
    logic [CHIP_W-1:0] chipIdx;
  } seqStrobe_t;

  function automatic stepInfo_t decodeStep(input logic [STEP_W-1:0] s);
    stepInfo_t r;
    r.isDelay = 1'b0;
    r.cmd     = MC_NOP;
    r.bank    = 2'd0;
    r.addr    = AD_ZERO;
    case (s)
      STEP_W'(0):  r.cmd = MC_NOP;
      STEP_W'(1):  r.cmd = MC_PREA;
      STEP_W'(2):  r.isDelay = 1'b1;
      STEP_W'(3):  begin r.cmd = MC_MRS; r.bank = 2'd2; end
      STEP_W'(4):  begin r.cmd = MC_MRS; r.bank = 2'd3; end
      STEP_W'(5):  begin r.cmd = MC_MRS; r.bank = 2'd1; r.addr = AD_EMR_EXIT; end
      STEP_W'(6):  begin r.cmd = MC_MRS; r.bank = 2'd0; r.addr = AD_MR_DLL; end
      STEP_W'(7):  r.cmd = MC_PREA;
      STEP_W'(8):  r.cmd = MC_AREF;
      STEP_W'(9):  r.cmd = MC_AREF;
      STEP_W'(10): begin r.cmd = MC_MRS; r.bank = 2'd0; r.addr = AD_MR_RUN; end
      STEP_W'(11): r.isDelay = 1'b1;
      STEP_W'(12): begin r.cmd = MC_MRS; r.bank = 2'd1; r.addr = AD_EMR_DEF; end
      STEP_W'(13): r.isDelay = 1'b1;
      STEP_W'(14): begin r.cmd = MC_MRS; r.bank = 2'd1; r.addr = AD_EMR_EXIT; end
      default:     r.isDelay = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] chipCount,
  input  logic [DLY_W-1:0] stepDelay,
  input  logic             cmdReady,
  output logic             cmdValid,
  output logic             done,
  output seqStrobe_t       strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seqState_e;

  seqState_e         state;
  logic [STEP_W-1:0] stepIdx;
  logic [CHIP_W-1:0] chipIdx;
  logic [CHIP_W-1:0] lastChipQ;
  logic [DLY_W-1:0]  dlyCfg;
  logic [DLY_W-1:0]  dlyCnt;

  logic [CNT_W-1:0]  effCount;
  logic [DLY_W-1:0]  effDelay;
  logic              atLastStep;
  logic              atLastChip;
  stepInfo_t         nextInfo;

  assign effCount   = (chipCount > CNT_W'(MAX_CHIPS)) ? CNT_W'(MAX_CHIPS) : chipCount;
  assign effDelay   = (stepDelay == '0) ? DLY_W'(1) : stepDelay;
  assign atLastStep = (stepIdx == STEP_W'(NUM_STEPS - 1));
  assign atLastChip = (chipIdx == lastChipQ);
  assign nextInfo   = decodeStep(stepIdx + STEP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepIdx   <= '0;
      chipIdx   <= '0;
      lastChipQ <= '0;
      dlyCfg    <= DLY_W'(1);
      dlyCnt    <= '0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            stepIdx <= '0;
            chipIdx <= '0;
            dlyCfg  <= effDelay;
            if (effCount == '0) begin
              done <= 1'b1;
            end else begin
              done      <= 1'b0;
              lastChipQ <= CHIP_W'(effCount - CNT_W'(1));
              state     <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (cmdReady) begin
            if (atLastStep) begin
              stepIdx <= '0;
              if (atLastChip) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                chipIdx <= chipIdx + CHIP_W'(1);
              end
            end else begin
              stepIdx <= stepIdx + STEP_W'(1);
              if (nextInfo.isDelay) begin
                state  <= ST_WAIT;
                dlyCnt <= dlyCfg;
              end
            end
          end
        end
        ST_WAIT: begin
          if (dlyCnt == DLY_W'(1)) begin
            stepIdx <= stepIdx + STEP_W'(1);
            state   <= ST_ISSUE;
          end else begin
            dlyCnt <= dlyCnt - DLY_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdValid        = (state == ST_ISSUE);
  assign strobe.loadCfg  = (state == ST_IDLE) && startPulse;
  assign strobe.stepIdx  = stepIdx;
  assign strobe.chipIdx  = chipIdx;

  // R8: a finished sequencer presents no command
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid);

  // R7: the chip index never passes the last populated chip
  a_r7_chip_bound: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (chipIdx <= lastChipQ));

  // R5: a pause counter stays within the sampled pause length
  a_r5_wait_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (dlyCnt != '0) && (dlyCnt <= dlyCfg));

endmodule

// File: rtl/ddr2_init_dp.sv
module ddr2_init_dp
  import ddr2_init_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [VAL_W-1:0] modeBase,
  input  logic [VAL_W-1:0] extModeBase,
  output logic [CMD_W-1:0] cmdWord
);

  logic [VAL_W-1:0] modeQ;
  logic [VAL_W-1:0] extQ;
  logic [VAL_W-1:0] ocdCleared;
  logic [VAL_W-1:0] valueField;
  stepInfo_t        info;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      extQ  <= '0;
    end else if (strobe.loadCfg) begin
      modeQ <= modeBase;
      extQ  <= extModeBase;
    end
  end

  assign info       = decodeStep(strobe.stepIdx);
  assign ocdCleared = extQ & ~OCD_MASK;

  always_comb begin
    case (info.addr)
      AD_MR_DLL:   valueField = modeQ | DLL_MASK;
      AD_MR_RUN:   valueField = modeQ & ~DLL_MASK;
      AD_EMR_DEF:  valueField = ocdCleared | OCD_MASK;
      AD_EMR_EXIT: valueField = ocdCleared;
      default:     valueField = '0;
    endcase
  end

  assign cmdWord = {1'b0, strobe.chipIdx, info.cmd, info.bank, valueField};

  // R6: every extended-register write carries calibration field 0 or 7
  a_r6_ocd_field: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWord[19:18] == 2'd2 && cmdWord[17:16] == 2'd1) |->
      (cmdWord[9:7] == 3'd0 || cmdWord[9:7] == 3'd7));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [2:0]       chipCount,
  input  logic [15:0]      modeBase,
  input  logic [15:0]      extModeBase,
  input  logic [DLY_W-1:0] stepDelay,
  input  logic             cmdReady,
  output logic             cmdValid,
  output logic [22:0]      cmdWord,
  output logic             done
);

  seqStrobe_t strobe;

  ddr2_init_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .chipCount  (chipCount),
    .stepDelay  (stepDelay),
    .cmdReady   (cmdReady),
    .cmdValid   (cmdValid),
    .done       (done),
    .strobe     (strobe)
  );

  ddr2_init_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .modeBase    (modeBase),
    .extModeBase (extModeBase),
    .cmdWord     (cmdWord)
  );

  // R4: a stalled command is held unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdWord)));

  // R2: the top bit of a presented word is zero
  a_r2_top_bit: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdWord[22] == 1'b0));

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;

  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [2:0]       chipCount = '0;
  logic [15:0]      modeBase = '0;
  logic [15:0]      extModeBase = '0;
  logic [DLY_W-1:0] stepDelay = '0;
  logic             cmdReady = 1'b0;
  logic             cmdValid;
  logic [22:0]      cmdWord;
  logic             done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ddr2_init_seq #(.DLY_W(DLY_W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chipCount(chipCount),
    .modeBase(modeBase), .extModeBase(extModeBase), .stepDelay(stepDelay),
    .cmdReady(cmdReady), .cmdValid(cmdValid), .cmdWord(cmdWord), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected word for command k (0..11) of a chip, built from R2, R3, R6
  function automatic logic [22:0] expCmd(input int chip, input int k,
                                         input logic [15:0] mb, input logic [15:0] eb);
    logic [1:0]  mc;
    logic [1:0]  bk;
    logic [15:0] v;
    mc = 2'd2; bk = 2'd0; v = 16'h0000;
    case (k)
      0: mc = 2'd3;
      1: mc = 2'd0;
      2: bk = 2'd2;
      3: bk = 2'd3;
      4: begin bk = 2'd1; v = eb & 16'hFC7F; end
      5: v = mb | 16'h0100;
      6: mc = 2'd0;
      7: mc = 2'd1;
      8: mc = 2'd1;
      9: v = mb & 16'hFEFF;
      10: begin bk = 2'd1; v = (eb & 16'hFC7F) | 16'h0380; end
      default: begin bk = 2'd1; v = eb & 16'hFC7F; end
    endcase
    return {1'b0, 2'(chip), mc, bk, v};
  endfunction

  function automatic bit pauseBefore(input int k);
    return (k == 2) || (k == 10) || (k == 11);
  endfunction

  task automatic runSeq(input int cnt, input logic [15:0] mb, input logic [15:0] eb,
                        input int dly, input int readyPct, input bit disturb);
    int effN;
    int pause;
    int idx;
    int gap;
    bit stalled;
    bit disturbOn;
    logic [22:0] heldWord;
    effN  = (cnt > 4) ? 4 : cnt;
    pause = (dly == 0) ? 1 : dly;
    @(negedge clk);
    chipCount = 3'(cnt); modeBase = mb; extModeBase = eb; stepDelay = DLY_W'(dly);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (effN == 0) begin
      chk(done === 1'b1 && cmdValid === 1'b0, "R10 zero count done", {30'd0, done, cmdValid}, 32'h2);
      for (int i = 0; i < 20; i++) begin
        if (cmdValid !== 1'b0) idx = 1;
        @(negedge clk);
      end
      chk(cmdValid === 1'b0, "R10 no command", {31'd0, cmdValid}, 32'd0);
      return;
    end
    chk(done === 1'b0, "R8 done cleared by start", {31'd0, done}, 32'd0);
    idx = 0; gap = 0; stalled = 1'b0; disturbOn = 1'b0; heldWord = '0;
    while (idx < effN * 12) begin
      if (disturbOn) begin
        startPulse = 1'b0;
        disturbOn = 1'b0;
      end
      if (stalled)
        chk(cmdValid === 1'b1 && cmdWord === heldWord, "R4 hold", {9'd0, cmdWord}, {9'd0, heldWord});
      if (cmdValid === 1'b1) begin
        bit rdy;
        rdy = ($urandom % 100) < readyPct;
        cmdReady = rdy;
        if (rdy) begin
          int k;
          k = idx % 12;
          chk(cmdWord === expCmd(idx / 12, k, mb, eb), "R3 R6 R7 word",
              {9'd0, cmdWord}, {9'd0, expCmd(idx / 12, k, mb, eb)});
          chk(gap == (pauseBefore(k) ? pause : 0), "R5 idle gap", gap, pauseBefore(k) ? pause : 0);
          idx++;
          gap = 0;
          if (disturb && idx == 5) begin
            startPulse = 1'b1;
            chipCount = 3'd1; modeBase = ~mb; extModeBase = ~eb; stepDelay = DLY_W'(dly + 7);
            disturbOn = 1'b1;
          end
        end
        stalled = !rdy;
        heldWord = cmdWord;
      end else begin
        cmdReady = ($urandom % 2) == 0;
        gap++;
        stalled = 1'b0;
      end
      @(negedge clk);
    end
    startPulse = 1'b0;
    cmdReady = 1'b0;
    chk(done === 1'b1 && cmdValid === 1'b0, "R8 done after last", {30'd0, done, cmdValid}, 32'h2);
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R8 done held", {31'd0, done}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'h0DD2_5EED));
    repeat (3) @(negedge clk);
    chk(cmdValid === 1'b0 && done === 1'b0, "R1 reset state", {30'd0, done, cmdValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmdValid === 1'b0 && done === 1'b0, "R1 idle after reset", {30'd0, done, cmdValid}, 32'd0);

    runSeq(1, 16'h0642, 16'h0004, 0, 100, 1'b0);   // R5 minimum pause
    runSeq(2, 16'h0742, 16'h0044, 5, 60, 1'b0);    // R4 back-pressure
    runSeq(4, 16'hFFFF, 16'hFFFF, 3, 100, 1'b1);   // R9 R11 mid-run start and changes
    runSeq(0, 16'h1234, 16'h5678, 2, 100, 1'b0);   // R10
    runSeq(7, 16'h0000, 16'h0380, 1, 50, 1'b0);    // R7 clamp to 4
    runSeq(3, 16'h0100, 16'h0040, 0, 40, 1'b1);    // R9 again
    for (int r = 0; r < 6; r++) begin
      runSeq($urandom % 6, 16'($urandom), 16'($urandom), $urandom % 8,
             30 + ($urandom % 71), 1'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule